// File: doc/BRIEF.md
# Line Status Monitor with Maskable Interrupts

This block supervises four status conditions of a single-channel T1/E1 line interface and turns their changes into maskable interrupts. It flags a stalled transmit clock, qualifies the in-band loopback activate and deactivate codes over a programmable hold time, follows the pattern-sync indication of an external PRBS/QRSS checker, and drives the remote-loopback enable of the line.

The transmit clock is asynchronous to the master clock. It is brought in through a synchronizer and watched with a cycle counter. The activate and deactivate inputs are level "code present" strobes from external code detectors. A code counts as received only after it has stayed present while a millisecond tick input advanced a timer to the selected hold time. That hold time is either short or long, chosen by a select input. Each status bit has an interrupt mask bit and an edge-select bit. Sticky pending bits are cleared by writing ones. A single interrupt line reports that any bit is pending.

Top module: `line_stat_mon`

## Requirements
- R1: Status bit 0 (transmit clock lost) is 1 once `tx_clk` has shown no edge for more than 70 master-clock cycles. It returns to 0 within a few cycles of `tx_clk` toggling again.
- R2: Status bit 1 (activate code qualified) is 0 until `lb_act_code` has been held high while `ms_tick` pulsed 40 times with `long_qual_sel` = 0. Registered on the clock edge of the 40th counted tick, it then reads 1. It returns to 0 on the first edge at which `lb_act_code` is low, and the tick count restarts from zero.
- R3: Status bit 2 (deactivate code qualified) obeys the R2 rule with `lb_deact_code` in place of `lb_act_code`.
- R4: With `long_qual_sel` = 1 the hold time of R2 and R3 is 5100 ticks instead of 40.
- R5: `remote_lb_en` resets to 0. It goes to 1 one cycle after status bit 1 rises and to 0 one cycle after status bit 2 rises. If both rise together, it goes to 0.
- R6: Status bit 3 (pattern sync) equals `prbs_sync_in` as sampled at the previous clock edge.
- R7: Reading address 0x17 returns the status bits in rd_data[3:0], ordered {sync, deactivate, activate, clock lost}, with the upper bits 0. All status bits reset to 0. Reading any address other than 0x17 or 0x18 returns 0.
- R8: A pending bit can only be set while its `irq_mask` bit is 0. A mask bit of 1 does not clear a bit that is already pending.
- R9: With its `irq_any_edge` bit at 0, a source sets its pending bit only on a 0-to-1 status change. With the bit at 1, any status change sets it. The pending bit is set one cycle after the status change.
- R10: Pending bits read at address 0x18, in rd_data[3:0] in the same order as R7. A write to 0x18 clears each pending bit whose `wr_data` bit is 1. Writes to any other address have no effect. A new event in the same cycle wins over the clear.
- R11: `irq` is 1 exactly when at least one pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_clk | input | 1 | Transmit clock, asynchronous to `clk` |
| lb_act_code | input | 1 | Activate code present (level) |
| lb_deact_code | input | 1 | Deactivate code present (level) |
| prbs_sync_in | input | 1 | Pattern checker in sync (synchronous level) |
| ms_tick | input | 1 | One-cycle millisecond tick |
| long_qual_sel | input | 1 | 1 selects the long hold time |
| irq_mask | input | 4 | Per-source interrupt mask, 1 blocks |
| irq_any_edge | input | 4 | Per-source edge select, 1 = any change |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 4 | Write-one-to-clear pattern |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data (combinational) |
| remote_lb_en | output | 1 | Remote loopback enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
A corrupted tick counter shows up as a status bit at 0x17 that rises one or more ticks early or late. A remote-loopback flag in the wrong state shows on `remote_lb_en` one cycle after the status edge that should have steered it. A wrong edge-history or pending flop shows on `irq` and at 0x18 in the cycle after the status change, and it stays there until a clear, because pending bits are sticky. A cycle-accurate model of the status, pending and loopback state is compared against the ports on every cycle. The exact hold-time boundaries, the simultaneous-rise priority and the clock-loss window are also checked directly.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    localparam int unsigned NSRC      = 4;
    localparam int unsigned SRC_LOST  = 0;
    localparam int unsigned SRC_ACT   = 1;
    localparam int unsigned SRC_DEACT = 2;
    localparam int unsigned SRC_SYNC  = 3;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/lsm_clk_watch.sv
module lsm_clk_watch #(
    parameter int unsigned LIMIT = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_clk,
    output logic lost
);
    localparam int unsigned CW = $clog2(LIMIT + 2);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
    localparam logic [CW-1:0] CMAX  = CW'(LIMIT + 1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
        logic          lost;
    } st_t;

    st_t s_d, s_q;
    logic seen_edge;

    always_comb begin
        s_d       = s_q;
        s_d.sync  = {s_q.sync[1:0], tx_clk};
        seen_edge = s_q.sync[2] ^ s_q.sync[1];
        if (seen_edge) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != CMAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.lost = (s_d.cnt > LIM_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lost = s_q.lost;
endmodule

// File: rtl/lsm_code_qual.sv
module lsm_code_qual #(
    parameter int unsigned SHORT_T = 40,
    parameter int unsigned LONG_T  = 5100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic code_in,
    input  logic tick,
    input  logic long_sel,
    output logic qual
);
    localparam int unsigned TW = $clog2(LONG_T + 1);
    localparam logic [TW-1:0] SHORT_V = TW'(SHORT_T);
    localparam logic [TW-1:0] LONG_V  = TW'(LONG_T);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          qual;
    } st_t;

    st_t s_d, s_q;
    logic [TW-1:0] lim;

    always_comb begin
        s_d = s_q;
        lim = long_sel ? LONG_V : SHORT_V;
        if (!code_in) begin
            s_d.cnt = '0;
        end else if (tick && (s_q.cnt < lim)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.qual = code_in && (s_d.cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign qual = s_q.qual;
endmodule

// File: rtl/lsm_irq_ctrl.sv
module lsm_irq_ctrl
    import lsm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t stat,
    input  src_vec_t mask,
    input  src_vec_t any_edge,
    input  src_vec_t clr,
    output src_vec_t pend,
    output logic     irq
);
    typedef struct packed {
        src_vec_t prev;
        src_vec_t pend;
    } st_t;

    st_t s_d, s_q;
    src_vec_t ev;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (any_edge[i]) ev[i] = stat[i] ^ s_q.prev[i];
            else             ev[i] = stat[i] & ~s_q.prev[i];
        end
        s_d.pend = (s_q.pend & ~clr) | (ev & ~mask);
        s_d.prev = stat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;
    assign irq  = |s_q.pend;
endmodule

// File: rtl/line_stat_mon.sv
module line_stat_mon
    import lsm_pkg::*;
#(
    parameter int unsigned LOSS_LIMIT = 70,
    parameter int unsigned QUAL_SHORT = 40,
    parameter int unsigned QUAL_LONG  = 5100,
    parameter int unsigned AW         = 8,
    parameter int unsigned DW         = 8,
    parameter logic [AW-1:0] STAT_ADDR = 8'h17,
    parameter logic [AW-1:0] PEND_ADDR = 8'h18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_clk,
    input  logic            lb_act_code,
    input  logic            lb_deact_code,
    input  logic            prbs_sync_in,
    input  logic            ms_tick,
    input  logic            long_qual_sel,
    input  logic [NSRC-1:0] irq_mask,
    input  logic [NSRC-1:0] irq_any_edge,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [NSRC-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            remote_lb_en,
    output logic            irq
);
    localparam int unsigned NCODE = 2;

    typedef struct packed {
        logic sync;
        logic act_prev;
        logic deact_prev;
        logic lb;
    } top_st_t;

    top_st_t  t_d, t_q;
    src_vec_t stat_w;
    src_vec_t pend_w;
    src_vec_t clr_w;
    logic     lost_w;
    logic [NCODE-1:0] code_w;
    logic [NCODE-1:0] qual_w;

    lsm_clk_watch #(.LIMIT(LOSS_LIMIT)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_clk (tx_clk),
        .lost   (lost_w)
    );

    assign code_w = {lb_deact_code, lb_act_code};

    for (genvar g = 0; g < int'(NCODE); g++) begin : g_qual
        lsm_code_qual #(
            .SHORT_T (QUAL_SHORT),
            .LONG_T  (QUAL_LONG)
        ) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .code_in  (code_w[g]),
            .tick     (ms_tick),
            .long_sel (long_qual_sel),
            .qual     (qual_w[g])
        );
    end

    always_comb begin
        stat_w            = '0;
        stat_w[SRC_LOST]  = lost_w;
        stat_w[SRC_ACT]   = qual_w[0];
        stat_w[SRC_DEACT] = qual_w[1];
        stat_w[SRC_SYNC]  = t_q.sync;
    end

    assign clr_w = (wr_en && (wr_addr == PEND_ADDR)) ? wr_data : '0;

    lsm_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat     (stat_w),
        .mask     (irq_mask),
        .any_edge (irq_any_edge),
        .clr      (clr_w),
        .pend     (pend_w),
        .irq      (irq)
    );

    always_comb begin
        t_d            = t_q;
        t_d.sync       = prbs_sync_in;
        t_d.act_prev   = stat_w[SRC_ACT];
        t_d.deact_prev = stat_w[SRC_DEACT];
        if (stat_w[SRC_DEACT] && !t_q.deact_prev) begin
            t_d.lb = 1'b0;
        end else if (stat_w[SRC_ACT] && !t_q.act_prev) begin
            t_d.lb = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign remote_lb_en = t_q.lb;

    always_comb begin
        rd_data = '0;
        if (rd_addr == STAT_ADDR)      rd_data[NSRC-1:0] = stat_w;
        else if (rd_addr == PEND_ADDR) rd_data[NSRC-1:0] = pend_w;
    end
endmodule

// File: rtl/lsm_chk.sv
module lsm_chk
    import lsm_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            act_code,
    input logic            deact_code,
    input logic [NSRC-1:0] mask,
    input logic [NSRC-1:0] any_edge,
    input logic [NSRC-1:0] stat,
    input logic [NSRC-1:0] pend,
    input logic            lb
);
    // R2: status drops on the edge after the code disappears
    assert_act_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !act_code |=> !stat[SRC_ACT]);

    // R2: a rising activate status needs the code at the edge that set it
    assert_act_needs_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[SRC_ACT]) |-> $past(act_code));

    // R3
    assert_deact_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !deact_code |=> !stat[SRC_DEACT]);

    // R5
    assert_lb_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat[SRC_ACT]) && !$rose(stat[SRC_DEACT])) |=> lb);

    assert_lb_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[SRC_DEACT]) |=> !lb);

    for (genvar k = 0; k < int'(NSRC); k++) begin : g_src
        // R8
        assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[k]) |-> !$past(mask[k]));

        // R9: in rising-only mode a falling status never creates a pending bit
        assert_fall_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!any_edge[k] && $fell(stat[k]) && !pend[k]) |=> !pend[k]);
    end
endmodule

bind line_stat_mon lsm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_code   (lb_act_code),
    .deact_code (lb_deact_code),
    .mask       (irq_mask),
    .any_edge   (irq_any_edge),
    .stat       (stat_w),
    .pend       (pend_w),
    .lb         (remote_lb_en)
);

// File: tb/tb_line_stat_mon.sv
module tb_line_stat_mon;
    localparam int SHORT_T = 40;
    localparam int LONG_T  = 5100;
    localparam logic [7:0] A_STAT = 8'h17;
    localparam logic [7:0] A_PEND = 8'h18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_clk = 1'b0;
    logic       tx_run = 1'b1;
    logic       act = 1'b0, deact = 1'b0, prbs = 1'b0, tick = 1'b0, long_sel = 1'b0;
    logic [3:0] mask = 4'hF, any_edge = 4'h0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [3:0] wr_data = 4'h0;
    logic [7:0] rd_addr = A_STAT;
    logic [7:0] rd_data;
    logic       lb, irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_en = 1'b1;
    bit done = 1'b0;

    // reference state
    int         m_cnt [1:2];
    logic [3:0] m_stat = 4'h0, m_prev = 4'h0, m_pend = 4'h0;
    logic       m_lb = 1'b0;

    always #5 clk = ~clk;
    always begin
        #37;
        if (tx_run) tx_clk = ~tx_clk;
    end

    line_stat_mon dut (
        .clk(clk), .rst_n(rst_n), .tx_clk(tx_clk),
        .lb_act_code(act), .lb_deact_code(deact), .prbs_sync_in(prbs),
        .ms_tick(tick), .long_qual_sel(long_sel),
        .irq_mask(mask), .irq_any_edge(any_edge),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .remote_lb_en(lb), .irq(irq)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, a, e);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] addr);
        if (addr == A_STAT) return {4'h0, m_stat};
        if (addr == A_PEND) return {4'h0, m_pend};
        return 8'h00;
    endfunction

    task automatic model_edge();
        logic [3:0] nstat, rise, chg, ev, clr;
        int lim;
        logic code;
        lim   = long_sel ? LONG_T : SHORT_T;
        nstat = 4'h0;
        for (int i = 1; i <= 2; i++) begin
            code = (i == 1) ? act : deact;
            if (!code) m_cnt[i] = 0;
            else if (tick && m_cnt[i] < lim) m_cnt[i]++;
            nstat[i] = code && (m_cnt[i] >= lim);
        end
        nstat[3] = prbs;
        rise = m_stat & ~m_prev;
        chg  = m_stat ^ m_prev;
        ev   = (chg & any_edge) | (rise & ~any_edge);
        clr  = (wr_en && wr_addr == A_PEND) ? wr_data : 4'h0;
        m_pend = (m_pend & ~clr) | (ev & ~mask);
        if (rise[2]) m_lb = 1'b0;
        else if (rise[1]) m_lb = 1'b1;
        m_prev = m_stat;
        m_stat = nstat;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (cmp_en) begin
            check("R7/R10 read port", rd_data, exp_read(rd_addr));
            check("R11 irq", irq, |m_pend);
            check("R5 remote loopback", lb, m_lb);
        end
    endtask

    task automatic get(input logic [7:0] addr, output logic [7:0] v);
        rd_addr = addr;
        #1;
        v = rd_data;
    endtask

    task automatic clear_all();
        wr_en = 1'b1; wr_addr = A_PEND; wr_data = 4'hF;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        logic [7:0] v, p;
        int seed;
        seed = $urandom(32'd20240611);
        m_cnt[1] = 0; m_cnt[2] = 0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        get(A_STAT, v); check("R7 status reset", v, 8'h00);
        get(A_PEND, v); check("R10 pending reset", v, 8'h00);
        check("R11 irq reset", irq, 1'b0);
        check("R5 loopback reset", lb, 1'b0);
        m_prev = 4'h0; m_stat = 4'h0;

        // ---- transmit clock loss ----
        cmp_en = 1'b0;
        mask = 4'h0; any_edge = 4'h0;
        tx_run = 1'b0;
        repeat (50) step();
        get(A_STAT, v); check("R1 no loss yet", v[0], 1'b0);
        repeat (50) step();
        get(A_STAT, v); check("R1 loss flagged", v[0], 1'b1);
        get(A_PEND, v); check("R9 rising edge pends", v[0], 1'b1);
        check("R11 irq on pending", irq, 1'b1);
        clear_all();
        get(A_PEND, v); check("R10 write-one clears", v, 8'h00);
        tx_run = 1'b1;
        repeat (20) step();
        get(A_STAT, v); check("R1 loss recovers", v[0], 1'b0);
        get(A_PEND, v); check("R9 fall ignored in rising mode", v[0], 1'b0);
        any_edge[0] = 1'b1;
        tx_run = 1'b0;
        repeat (100) step();
        clear_all();
        tx_run = 1'b1;
        repeat (20) step();
        get(A_PEND, v); check("R9 fall pends in any mode", v[0], 1'b1);
        clear_all();
        mask[0] = 1'b1;
        tx_run = 1'b0;
        repeat (100) step();
        get(A_PEND, v); check("R8 masked source stays clear", v[0], 1'b0);
        check("R8 irq quiet while masked", irq, 1'b0);
        tx_run = 1'b1;
        repeat (20) step();
        mask = 4'h0; any_edge = 4'h0;
        clear_all();
        cmp_en = 1'b1;

        // ---- qualification, short hold ----
        tick = 1'b1;
        act = 1'b1;
        repeat (SHORT_T - 1) step();
        get(A_STAT, v); check("R2 one tick short", v[1], 1'b0);
        step();
        get(A_STAT, v); check("R2 qualified at 40", v[1], 1'b1);
        step();
        check("R5 loopback on", lb, 1'b1);
        get(A_PEND, v); check("R9 activate pending", v[1], 1'b1);
        act = 1'b0;
        step();
        get(A_STAT, v); check("R2 drops with code", v[1], 1'b0);
        deact = 1'b1;
        repeat (SHORT_T) step();
        get(A_STAT, v); check("R3 deactivate qualified", v[2], 1'b1);
        step();
        check("R5 loopback off", lb, 1'b0);
        deact = 1'b0;
        step();
        act = 1'b1;
        repeat (SHORT_T + 1) step();
        act = 1'b0;
        step();
        check("R5 loopback on again", lb, 1'b1);
        act = 1'b1; deact = 1'b1;
        repeat (SHORT_T + 1) step();
        check("R5 deactivate wins on tie", lb, 1'b0);
        act = 1'b0; deact = 1'b0;
        step();

        // ---- pattern sync ----
        prbs = 1'b1;
        step();
        get(A_STAT, v); check("R6 sync follows", v[3], 1'b1);
        prbs = 1'b0;
        step();
        get(A_STAT, v); check("R6 sync drops", v[3], 1'b0);

        // ---- writes to the wrong address ----
        get(A_PEND, p);
        wr_en = 1'b1; wr_addr = A_STAT; wr_data = 4'hF;
        step();
        wr_en = 1'b0;
        get(A_PEND, v); check("R10 stray write ignored", v, p);
        get(8'h30, v); check("R7 unmapped read", v, 8'h00);

        // ---- long hold ----
        clear_all();
        long_sel = 1'b1;
        act = 1'b1;
        repeat (LONG_T - 1) step();
        get(A_STAT, v); check("R4 one tick short of long hold", v[1], 1'b0);
        step();
        get(A_STAT, v); check("R4 long hold reached", v[1], 1'b1);
        act = 1'b0;
        step();
        long_sel = 1'b0;

        // ---- random traffic ----
        for (int n = 0; n < 8000; n++) begin
            if ($urandom_range(49) == 0) act = ~act;
            if ($urandom_range(49) == 0) deact = ~deact;
            if ($urandom_range(19) == 0) prbs = ~prbs;
            tick = ($urandom_range(3) != 0);
            if ($urandom_range(199) == 0) mask = 4'($urandom);
            if ($urandom_range(199) == 0) any_edge = 4'($urandom);
            wr_en = ($urandom_range(9) == 0);
            case ($urandom_range(3))
                0: wr_addr = A_STAT;
                3: wr_addr = 8'h05;
                default: wr_addr = A_PEND;
            endcase
            wr_data = 4'($urandom);
            case ($urandom_range(2))
                0: rd_addr = A_STAT;
                1: rd_addr = A_PEND;
                default: rd_addr = 8'h22;
            endcase
            step();
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule